// File: doc/BRIEF.md
# LCD raster timing generator

This block produces the raster timing for a parallel RGB panel. It drives horizontal sync, vertical sync and data-enable, along with the column and row of the current pixel inside the visible area. Each line and each frame is built from four segments taken from packed configuration words: sync pulse, back porch, active region and front porch. Every length is stored one below its true value, except the vertical back porch, which is stored as the actual line count and may therefore be zero.

Two enables bring the panel up in stages. The sync enable starts the counters and the sync pulses. The display enable also has to be high before data-enable can assert. When a frame starts, a status flag is set. That flag drives an interrupt line through a mask, which is set by an enable strobe and cleared by a disable strobe. A read strobe clears the flag. A 4-bit format code is decoded into a one-hot selection of the panel bus format.

Top module: `lcd_raster_timing`

## Requirements
- R1: While reset is asserted, den is 0, pix_x and pix_y are 0, irq and int_status are 0, and hsync and vsync sit at their inactive levels (equal to hs_inv and vs_inv).
- R2: A line is made of these segments in order: sync for cfg_sync[CW-1:0]+1 clocks, back porch for cfg_hporch[2CW-1:CW]+1, active for cfg_active[CW-1:0]+1 and front porch for cfg_hporch[CW-1:0]+1. The horizontal count returns to 0 after its last clock.
- R3: A frame is made of these line segments in order: sync for cfg_sync[2CW-1:CW]+1 lines, back porch for exactly cfg_vporch[2CW-1:CW] lines (zero is allowed), active for cfg_active[2CW-1:CW]+1 and front porch for cfg_vporch[CW-1:0]+1. The line count advances on the last clock of each line.
- R4: hsync is high during the horizontal sync segment when hs_inv is 0, and the output is inverted when hs_inv is 1. vsync follows the same rule with vs_inv.
- R5: den is 1 only when sync_en and disp_en are both 1 and both counts are inside their active segments.
- R6: pix_x is the offset of the horizontal count from the start of the active segment, and it is 0 outside that segment. pix_y is the same for the line count.
- R7: While sync_en is 0, both counts are held at 0, the syncs stay inactive and no start-of-frame event occurs. Counting resumes from 0.
- R8: A start-of-frame event occurs on the single clock in which sync_en is 1 and both counts are 0. It sets int_status on the following edge. int_rd clears int_status, but a start-of-frame event in the same clock takes priority.
- R9: int_en sets the mask and int_dis clears it, with int_dis taking priority. irq equals int_status AND the mask.
- R10: bus_fmt is one-hot: code 0 gives bit 0 (12-bit RGB), 1 gives bit 1 (16-bit), 2 gives bit 2 (18-bit) and 3 gives bit 3 (24-bit). Codes 4 to 15 give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_en | input | 1 | Runs the counters and sync outputs |
| disp_en | input | 1 | Allows data-enable |
| cfg_sync | input | 2*CW | Low: hsync width-1, high: vsync width-1 |
| cfg_vporch | input | 2*CW | Low: vertical front porch-1, high: vertical back porch (unbiased) |
| cfg_hporch | input | 2*CW | Low: horizontal front porch-1, high: horizontal back porch-1 |
| cfg_active | input | 2*CW | Low: active width-1, high: active height-1 |
| hs_inv | input | 1 | Makes hsync active-low |
| vs_inv | input | 1 | Makes vsync active-low |
| fmt_code | input | 4 | Bus format code |
| int_en | input | 1 | Strobe that unmasks the frame interrupt |
| int_dis | input | 1 | Strobe that masks the frame interrupt |
| int_rd | input | 1 | Status read strobe, clears status |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| den | output | 1 | Data enable |
| pix_x | output | CW | Column within the active area |
| pix_y | output | CW | Row within the active area |
| irq | output | 1 | Masked frame interrupt |
| int_status | output | 1 | Start-of-frame status flag |
| bus_fmt | output | 4 | One-hot bus format select |

## Verification
The hardest case to reach is a status read that lands on the exact clock of the start-of-frame event, since that clock comes only once per frame. The stimulus tracks the frame origin in its own model and raises the read strobe on that clock about half the time. Random small configurations, including a zero vertical back porch and minimum segment lengths, keep frames short enough to span many frames. Random toggling of the enables and mask strobes covers staged bring-up and mask priority.

// File: rtl/lrt_pkg.sv
package lrt_pkg;
   localparam int FMT_CODES = 4;

   function automatic logic [FMT_CODES-1:0] fmt_onehot(input logic [3:0] code);
      logic [FMT_CODES-1:0] sel;
      sel = '0;
      for (int i = 0; i < FMT_CODES; i++) begin
         if (code == 4'(i)) sel[i] = 1'b1;
      end
      return sel;
   endfunction
endpackage

// File: rtl/lrt_axis_cnt.sv
module lrt_axis_cnt #(
   parameter int CW        = 16,
   parameter bit BP_BIASED = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          step,
   input  logic [CW-1:0] sync_f,
   input  logic [CW-1:0] bp_f,
   input  logic [CW-1:0] act_f,
   input  logic [CW-1:0] fp_f,
   output logic          at_origin,
   output logic          wrap,
   output logic          in_sync,
   output logic          in_act,
   output logic [CW-1:0] pos
);
   localparam int CNTW = CW + 3;

   if (CW < 2 || CW > 16) begin : g_bad_cw
      $error("lrt_axis_cnt: CW out of range");
   end

   logic [CNTW-1:0] cnt;
   logic [CNTW-1:0] sync_len, bp_len, act_start, act_end, total;

   if (BP_BIASED) begin : g_bp_biased
      assign bp_len = CNTW'(bp_f) + CNTW'(1);
   end else begin : g_bp_plain
      assign bp_len = CNTW'(bp_f);
   end

   assign sync_len  = CNTW'(sync_f) + CNTW'(1);
   assign act_start = sync_len + bp_len;
   assign act_end   = act_start + CNTW'(act_f) + CNTW'(1);
   assign total     = act_end + CNTW'(fp_f) + CNTW'(1);

   assign wrap      = (cnt >= total - CNTW'(1));
   assign at_origin = (cnt == '0);
   assign in_sync   = (cnt < sync_len);
   assign in_act    = (cnt >= act_start) && (cnt < act_end);
   assign pos       = in_act ? CW'(cnt - act_start) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (clr)     cnt <= '0;
      else if (step)    cnt <= wrap ? '0 : cnt + CNTW'(1);
   end

   // R2 (and R3 for the line axis): count wraps to zero after the last position
   a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr && wrap) |=> at_origin);
   // R7: clear holds the count at zero
   a_r7_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> at_origin);
   // R6: active position lies inside the segment
   a_r6_pos_bound: assert property (@(posedge clk) disable iff (!rst_n)
      in_act |-> (pos <= act_f));
endmodule

// File: rtl/lrt_irq.sv
module lrt_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic sof,
   input  logic en_wr,
   input  logic dis_wr,
   input  logic stat_rd,
   output logic status,
   output logic irq
);
   logic mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= 1'b0;
         mask   <= 1'b0;
      end else begin
         if (sof)          status <= 1'b1;
         else if (stat_rd) status <= 1'b0;
         if (dis_wr)       mask <= 1'b0;
         else if (en_wr)   mask <= 1'b1;
      end
   end

   assign irq = status & mask;

   // R8: a frame start always leaves the flag set
   a_r8_sof_sets: assert property (@(posedge clk) disable iff (!rst_n)
      sof |=> status);
   // R8: a read without a concurrent frame start clears the flag
   a_r8_rd_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !sof) |=> !status);
   // R9: a rising interrupt needs a frame start or an unmask just before
   a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(sof) || $past(en_wr)));
   // R9: disable masks the line
   a_r9_dis_masks: assert property (@(posedge clk) disable iff (!rst_n)
      dis_wr |=> !irq);
endmodule

// File: rtl/lcd_raster_timing.sv
module lcd_raster_timing #(
   parameter int CW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sync_en,
   input  logic            disp_en,
   input  logic [2*CW-1:0] cfg_sync,
   input  logic [2*CW-1:0] cfg_vporch,
   input  logic [2*CW-1:0] cfg_hporch,
   input  logic [2*CW-1:0] cfg_active,
   input  logic            hs_inv,
   input  logic            vs_inv,
   input  logic [3:0]      fmt_code,
   input  logic            int_en,
   input  logic            int_dis,
   input  logic            int_rd,
   output logic            hsync,
   output logic            vsync,
   output logic            den,
   output logic [CW-1:0]   pix_x,
   output logic [CW-1:0]   pix_y,
   output logic            irq,
   output logic            int_status,
   output logic [3:0]      bus_fmt
);
   import lrt_pkg::*;

   logic h_org, h_wrap, h_sync, h_act;
   logic v_org, v_wrap, v_sync, v_act;
   logic sof;

   lrt_axis_cnt #(.CW(CW), .BP_BIASED(1'b1)) h_cnt_i (
      .clk(clk), .rst_n(rst_n), .clr(!sync_en), .step(sync_en),
      .sync_f(cfg_sync[CW-1:0]), .bp_f(cfg_hporch[2*CW-1:CW]),
      .act_f(cfg_active[CW-1:0]), .fp_f(cfg_hporch[CW-1:0]),
      .at_origin(h_org), .wrap(h_wrap), .in_sync(h_sync), .in_act(h_act),
      .pos(pix_x));

   lrt_axis_cnt #(.CW(CW), .BP_BIASED(1'b0)) v_cnt_i (
      .clk(clk), .rst_n(rst_n), .clr(!sync_en), .step(sync_en && h_wrap),
      .sync_f(cfg_sync[2*CW-1:CW]), .bp_f(cfg_vporch[2*CW-1:CW]),
      .act_f(cfg_active[2*CW-1:CW]), .fp_f(cfg_vporch[CW-1:0]),
      .at_origin(v_org), .wrap(v_wrap), .in_sync(v_sync), .in_act(v_act),
      .pos(pix_y));

   assign sof = sync_en && h_org && v_org;

   lrt_irq irq_i (
      .clk(clk), .rst_n(rst_n), .sof(sof), .en_wr(int_en), .dis_wr(int_dis),
      .stat_rd(int_rd), .status(int_status), .irq(irq));

   assign hsync   = (sync_en && h_sync) ^ hs_inv;
   assign vsync   = (sync_en && v_sync) ^ vs_inv;
   assign den     = sync_en && disp_en && h_act && v_act;
   assign bus_fmt = fmt_onehot(fmt_code);

   // R5: data enable only with both staged enables
   a_r5_den_gated: assert property (@(posedge clk) disable iff (!rst_n)
      den |-> (sync_en && disp_en));
   // R8: the frame start lasts a single clock
   a_r8_sof_single: assert property (@(posedge clk) disable iff (!rst_n)
      sof |=> !sof);
   // R7: syncs idle while the sync stage is off
   a_r7_sync_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_en |-> (hsync == hs_inv && vsync == vs_inv));
   // R10: format select is never more than one-hot
   a_r10_fmt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bus_fmt));
   // R6: active data implies the line is inside the active rows
   a_r6_den_rows: assert property (@(posedge clk) disable iff (!rst_n)
      den |-> v_act);
   // R2: the last clock of a line is never the first one after reset of the count
   a_r2_wrap_after_origin: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_en && h_org) |-> !h_wrap);
endmodule

// File: tb/lcd_raster_timing_tb_top.sv
module lcd_raster_timing_tb_top;
   localparam int CW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sync_en = 0, disp_en = 0, hs_inv = 0, vs_inv = 0;
   logic int_en = 0, int_dis = 0, int_rd = 0;
   logic [3:0] fmt_code = '0;
   logic [2*CW-1:0] cfg_sync = '0, cfg_vporch = '0, cfg_hporch = '0, cfg_active = '0;
   logic hsync, vsync, den, irq, int_status;
   logic [CW-1:0] pix_x, pix_y;
   logic [3:0] bus_fmt;

   always #2 clk = ~clk;

   lcd_raster_timing #(.CW(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .disp_en(disp_en),
      .cfg_sync(cfg_sync), .cfg_vporch(cfg_vporch), .cfg_hporch(cfg_hporch),
      .cfg_active(cfg_active), .hs_inv(hs_inv), .vs_inv(vs_inv),
      .fmt_code(fmt_code), .int_en(int_en), .int_dis(int_dis), .int_rd(int_rd),
      .hsync(hsync), .vsync(vsync), .den(den), .pix_x(pix_x), .pix_y(pix_y),
      .irq(irq), .int_status(int_status), .bus_fmt(bus_fmt));

   int n_chk = 0, n_fail = 0;
   int hs, hb, ha, hf, vs, vb, va, vf;
   int mh = 0, mv = 0;
   bit mstat = 0, mmask = 0;
   bit done = 0;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (h=%0d v=%0d)", tag, act, exp, mh, mv);
      end
   endtask

   function automatic int h_tot();  return hs + 1 + hb + 1 + ha + 1 + hf + 1; endfunction
   function automatic int v_tot();  return vs + 1 + vb + va + 1 + vf + 1;     endfunction

   task automatic apply_cfg();
      cfg_sync   = {CW'(vs), CW'(hs)};
      cfg_vporch = {CW'(vb), CW'(vf)};
      cfg_hporch = {CW'(hb), CW'(hf)};
      cfg_active = {CW'(va), CW'(ha)};
   endtask

   task automatic check_outputs();
      int has, hae, vas, vae, fe;
      bit hin, vin, hact, vact;
      has = hs + 1 + hb + 1;  hae = has + ha + 1;
      vas = vs + 1 + vb;      vae = vas + va + 1;
      hin  = sync_en && (mh < hs + 1);
      vin  = sync_en && (mv < vs + 1);
      hact = (mh >= has) && (mh < hae);
      vact = (mv >= vas) && (mv < vae);
      chk(sync_en ? "R2/R4 hsync" : "R7 hsync", int'(hsync), int'(hin ^ hs_inv));
      chk(sync_en ? "R3/R4 vsync" : "R7 vsync", int'(vsync), int'(vin ^ vs_inv));
      chk("R5 den", int'(den), int'(sync_en && disp_en && hact && vact));
      chk("R6 pix_x", int'(pix_x), hact ? mh - has : 0);
      chk("R6 pix_y", int'(pix_y), vact ? mv - vas : 0);
      chk("R8 int_status", int'(int_status), int'(mstat));
      chk("R9 irq", int'(irq), int'(mstat && mmask));
      fe = (int'(fmt_code) < 4) ? (1 << int'(fmt_code)) : 0;
      chk("R10 bus_fmt", int'(bus_fmt), fe);
   endtask

   task automatic run_cycle(input bit se);
      bit sof, hw;
      sync_en = se;
      disp_en = ($urandom_range(0, 9) != 0);
      int_en  = ($urandom_range(0, 15) == 0);
      int_dis = ($urandom_range(0, 40) == 0);
      int_rd  = ($urandom_range(0, 7) == 0);
      if (se && mh == 0 && mv == 0 && $urandom_range(0, 1) == 1) int_rd = 1'b1;
      #1;
      check_outputs();
      sof   = se && (mh == 0) && (mv == 0);
      mstat = sof ? 1'b1 : (int_rd ? 1'b0 : mstat);
      mmask = int_dis ? 1'b0 : (int_en ? 1'b1 : mmask);
      if (!se) begin
         mh = 0; mv = 0;
      end else begin
         hw = (mh >= h_tot() - 1);
         mh = hw ? 0 : mh + 1;
         if (hw) mv = (mv >= v_tot() - 1) ? 0 : mv + 1;
      end
      @(negedge clk);
   endtask

   task automatic run_config();
      apply_cfg();
      hs_inv   = 1'($urandom_range(0, 1));
      vs_inv   = 1'($urandom_range(0, 1));
      fmt_code = 4'($urandom_range(0, 15));
      repeat (3) run_cycle(1'b0);
      repeat (2 * h_tot() * v_tot() + 5) run_cycle(1'b1);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd20240611));
      hs = 0; hb = 0; ha = 0; hf = 0; vs = 0; vb = 0; va = 0; vf = 0;
      apply_cfg();
      @(negedge clk);
      @(negedge clk);
      #1;
      // R1: reset state
      chk("R1 den", int'(den), 0);
      chk("R1 pix_x", int'(pix_x), 0);
      chk("R1 pix_y", int'(pix_y), 0);
      chk("R1 irq", int'(irq), 0);
      chk("R1 int_status", int'(int_status), 0);
      chk("R1 hsync", int'(hsync), int'(hs_inv));
      chk("R1 vsync", int'(vsync), int'(vs_inv));
      @(negedge clk);
      rst_n = 1'b1;
      // directed: every segment at its minimum (R2, R3 with zero back porch)
      run_config();
      // directed: nonzero unbiased vertical back porch (R3)
      hs = 1; hb = 2; ha = 3; hf = 0; vs = 0; vb = 3; va = 2; vf = 1;
      run_config();
      for (int k = 0; k < 12; k++) begin
         hs = $urandom_range(0, 3); hb = $urandom_range(0, 3);
         ha = $urandom_range(0, 7); hf = $urandom_range(0, 3);
         vs = $urandom_range(0, 3); vb = $urandom_range(0, 3);
         va = $urandom_range(0, 6); vf = $urandom_range(0, 3);
         run_config();
      end
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule